// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block generates one pulse-width modulated output per channel, with one or two channels chosen when the block is built. Each channel divides the input clock by a programmable prescale factor to form its tick. It counts ticks up to a programmable period value and holds its output high for a programmable number of ticks at the start of each period. A flag forces the output high for the full period. Software programs the channels through a single-cycle register bus. A per-channel enable input starts a channel and stops it.

When a channel is disabled, one of two stop behaviours applies. In the abrupt mode, the channel halts and drops its output at the next clock. In the graceful mode, the channel finishes the period it is in before it goes idle. Register writes go to staged copies. A running channel takes them up only when a period ends or when it starts, so a reprogrammed period never comes out as a mix of old and new settings.

Top module: `pwm_ctrl`

## Requirements
- R1: Registers are decoded from address bits [7:2] with bits [1:0] ignored. Bit 4 selects the channel. Bits [3:2] select the register: 0 is control, 1 is duty, 2 is period and 3 reads as zero. Any set bit in [7:5] makes the access unmapped. Control holds the prescale in [5:0] and the abrupt-stop flag in bit 6. Duty holds the duty count in [9:0] and the full-duty flag in bit 10. Period holds the period count in [9:0]. Reads return the staged values combinationally, and every unused bit reads as zero.
- R2: While a channel runs, one output period lasts (prescale+1)*(period count+1) clocks.
- R3: The output is high during the first (prescale+1)*(duty count) clocks of each period and low for the rest of it.
- R4: While the full-duty flag is set, the output is high for the whole period whatever the duty count holds.
- R5: A duty count of 0 gives a constant low output. A duty count above the period count, with the full-duty flag clear, gives a constant high output.
- R6: A write to a channel does not change the channel's running period. The channel loads the staged prescale, duty and period values in the clock edge where it starts (enable high while idle) and in the edge where a period ends with the enable still high. A channel starts in the edge after the enable is seen high, and its first period begins in the next cycle.
- R7: With the abrupt-stop flag set, a running channel that sees its enable low stops in that clock edge. Its output is low from the next cycle.
- R8: With the abrupt-stop flag clear, a running channel that sees its enable low completes its current period. It goes idle at the period end, with its output low from then on. If the enable returns high before the period ends, the channel continues without a break.
- R9: After reset all staged registers are zero, the channels are idle and every output is low. An idle channel drives its output low.
- R10: When the block is built with one channel, accesses to channel 1 addresses read as zero and writes to them have no effect.
- R11: Two channels run independently, each with its own settings, enable and period timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register byte address |
| we_i | input | 1 | Write strobe for the current cycle |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ch_en_i | input | NUM_CH | Per-channel run enable |
| pwm_o | output | NUM_CH | Per-channel modulated output |

## Verification
Two kinds of collision can land in the same clock edge. The first is a period end meeting a register write. The second is a period end meeting a falling enable. The bench sweeps a write of new duty and period values across every cycle offset of a running period, including the boundary cycle itself. It also drops the enable at each offset in both stop modes. Each case is judged by a behavioural model that counts elapsed clocks within the period and compares the output on every cycle. In that model, a write in the boundary edge affects only the following period.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PS_W  = 6;
  localparam int CNT_W = 10;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_DUTY = 2'd1,
    REG_PER  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic             sd;   // abrupt stop
    logic [PS_W-1:0]  ps;
    logic             fd;   // full duty
    logic [CNT_W-1:0] dc;
    logic [CNT_W-1:0] pv;
  } ch_cfg_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic                          we_i,
  input  logic [DATA_W-1:0]             wdata_i,
  output logic [DATA_W-1:0]             rdata_o,
  output ch_cfg_t [NUM_CH-1:0]          cfg_o
);
  localparam int CH_BIT = 4;
  localparam int HI_LSB = CH_BIT + 1;

  logic     hit;
  logic     ch_sel;
  reg_sel_e reg_sel;
  logic     unused_bits;

  assign ch_sel  = addr_i[CH_BIT];
  assign reg_sel = reg_sel_e'(addr_i[3:2]);
  assign hit     = (addr_i[ADDR_W-1:HI_LSB] == '0) && (int'(ch_sel) < NUM_CH);
  assign unused_bits = ^{wdata_i[DATA_W-1:CNT_W+1], addr_i[1:0]};

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr;
    assign wr = we_i && hit && (int'(ch_sel) == i);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_o[i] <= '0;
      end else if (wr) begin
        unique case (reg_sel)
          REG_CTRL: begin
            cfg_o[i].ps <= wdata_i[PS_W-1:0];
            cfg_o[i].sd <= wdata_i[PS_W];
          end
          REG_DUTY: begin
            cfg_o[i].dc <= wdata_i[CNT_W-1:0];
            cfg_o[i].fd <= wdata_i[CNT_W];
          end
          REG_PER:  cfg_o[i].pv <= wdata_i[CNT_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit && (int'(ch_sel) == i)) begin
        unique case (reg_sel)
          REG_CTRL: rdata_o = DATA_W'({cfg_o[i].sd, cfg_o[i].ps});
          REG_DUTY: rdata_o = DATA_W'({cfg_o[i].fd, cfg_o[i].dc});
          REG_PER:  rdata_o = DATA_W'(cfg_o[i].pv);
          default:  rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         run_i,
  input  logic [W-1:0] lim_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == lim_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  ch_cfg_t cfg_i,
  output logic    pwm_o,
  output logic    run_o,
  output logic    pend_o
);
  logic             run_q;
  logic [PS_W-1:0]  a_ps;
  logic [CNT_W-1:0] a_dc, a_pv, per_q;
  logic             a_fd;
  logic             tick, start, stop_now;

  assign start    = !run_q && en_i;
  assign stop_now = run_q && !en_i && cfg_i.sd;
  assign pend_o   = tick && (per_q == a_pv);
  assign run_o    = run_q;
  assign pwm_o    = run_q && (a_fd || (per_q < a_dc));

  pwm_prescale #(.W(PS_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start || stop_now),
    .run_i  (run_q),
    .lim_i  (a_ps),
    .tick_o (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      per_q <= '0;
      a_ps  <= '0;
      a_dc  <= '0;
      a_pv  <= '0;
      a_fd  <= 1'b0;
    end else if (start) begin
      run_q <= 1'b1;
      per_q <= '0;
      a_ps  <= cfg_i.ps;
      a_dc  <= cfg_i.dc;
      a_pv  <= cfg_i.pv;
      a_fd  <= cfg_i.fd;
    end else if (stop_now) begin
      run_q <= 1'b0;
      per_q <= '0;
    end else if (pend_o) begin
      per_q <= '0;
      if (en_i) begin
        a_ps <= cfg_i.ps;
        a_dc <= cfg_i.dc;
        a_pv <= cfg_i.pv;
        a_fd <= cfg_i.fd;
      end else begin
        run_q <= 1'b0;
      end
    end else if (tick) begin
      per_q <= per_q + 1'b1;
    end
  end
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_CH-1:0] ch_en_i,
  output logic [NUM_CH-1:0] pwm_o
);
  ch_cfg_t [NUM_CH-1:0] cfg;
  logic [NUM_CH-1:0]    run_w, pend_w, sd_w;

  pwm_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr_i),
    .we_i    (we_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .cfg_o   (cfg)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign sd_w[i] = cfg[i].sd;
    pwm_chan u_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (ch_en_i[i]),
      .cfg_i  (cfg[i]),
      .pwm_o  (pwm_o[i]),
      .run_o  (run_w[i]),
      .pend_o (pend_w[i])
    );
  end
endmodule

// File: rtl/pwm_ctrl_chk.sv
module pwm_ctrl_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [31:0]       rdata_o,
  input logic [NUM_CH-1:0] ch_en_i,
  input logic [NUM_CH-1:0] run_w,
  input logic [NUM_CH-1:0] pend_w,
  input logic [NUM_CH-1:0] sd_w
);
  // R1
  reg3_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[3:2] == 2'b11) |-> (rdata_o == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    // R6
    start_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_w[i] && ch_en_i[i]) |=> run_w[i]);
    // R7
    abrupt_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[i] && !ch_en_i[i] && sd_w[i]) |=> !run_w[i]);
    // R8
    graceful_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[i] && !ch_en_i[i] && !sd_w[i] && !pend_w[i]) |=> run_w[i]);
    // R8
    graceful_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_w[i] && !ch_en_i[i] && pend_w[i]) |=> !run_w[i]);
  end
endmodule

bind pwm_ctrl pwm_ctrl_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_pwm_ctrl.sv
module tb_pwm_ctrl;
  logic        clk_i = 0;
  logic        rst_ni = 0;
  logic [7:0]  addr = 0;
  logic        we = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic [1:0]  en = 0;
  logic [1:0]  pwm;
  logic [7:0]  addr1 = 0;
  logic        we1 = 0;
  logic [31:0] wdata1 = 0;
  logic [31:0] rdata1;
  logic [0:0]  en1 = 0;
  logic [0:0]  pwm1;

  int    n_run = 0, n_fail = 0, cyc = 0;
  bit    cmp_on = 0;
  string cur_req = "R9";

  always #2 clk_i = ~clk_i;

  pwm_ctrl #(.NUM_CH(2)) dut (.clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr), .we_i(we),
    .wdata_i(wdata), .rdata_o(rdata), .ch_en_i(en), .pwm_o(pwm));
  pwm_ctrl #(.NUM_CH(1)) dut_one (.clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr1), .we_i(we1),
    .wdata_i(wdata1), .rdata_o(rdata1), .ch_en_i(en1), .pwm_o(pwm1));

  // behavioural model: elapsed clocks within the period
  int sh_ps[2], sh_sd[2], sh_dc[2], sh_fd[2], sh_pv[2];
  int a_ps[2], a_dc[2], a_fd[2], a_pv[2], t[2];
  bit m_run[2];

  function automatic bit m_out(int c);
    return m_run[c] && (a_fd[c] != 0 || t[c] < (a_ps[c] + 1) * a_dc[c]);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < 2; c++) begin
        sh_ps[c] = 0; sh_sd[c] = 0; sh_dc[c] = 0; sh_fd[c] = 0; sh_pv[c] = 0;
        a_ps[c] = 0; a_dc[c] = 0; a_fd[c] = 0; a_pv[c] = 0; t[c] = 0; m_run[c] = 0;
      end
    end else begin
      for (int c = 0; c < 2; c++) begin
        int len;
        len = (a_ps[c] + 1) * (a_pv[c] + 1);
        if (m_run[c] && !en[c] && sh_sd[c] != 0) begin
          m_run[c] = 0; t[c] = 0;
        end else if (m_run[c]) begin
          if (t[c] == len - 1) begin
            t[c] = 0;
            if (en[c]) begin
              a_ps[c] = sh_ps[c]; a_dc[c] = sh_dc[c]; a_fd[c] = sh_fd[c]; a_pv[c] = sh_pv[c];
            end else m_run[c] = 0;
          end else t[c]++;
        end else if (en[c]) begin
          m_run[c] = 1; t[c] = 0;
          a_ps[c] = sh_ps[c]; a_dc[c] = sh_dc[c]; a_fd[c] = sh_fd[c]; a_pv[c] = sh_pv[c];
        end
      end
      if (we && addr[7:5] == 0) begin
        int c;
        c = addr[4];
        case (addr[3:2])
          2'd0: begin sh_ps[c] = wdata[5:0]; sh_sd[c] = wdata[6]; end
          2'd1: begin sh_dc[c] = wdata[9:0]; sh_fd[c] = wdata[10]; end
          2'd2: sh_pv[c] = wdata[9:0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    if (cmp_on) begin
      for (int c = 0; c < 2; c++)
        check(pwm[c] == m_out(c), cur_req, $sformatf("pwm ch%0d t=%0d", c, t[c]),
              int'(pwm[c]), int'(m_out(c)));
      check(pwm1 == 1'b0, "R9", "idle single-channel pwm", int'(pwm1), 0);
    end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk_i);
    addr = 8'(a); wdata = 32'(d); we = 1;
    @(negedge clk_i);
    we = 0; addr = 0;
  endtask

  task automatic rd(int a, int exp, string req);
    @(negedge clk_i);
    addr = 8'(a);
    #1 check(rdata == 32'(exp), req, $sformatf("read @%0h", a), int'(rdata), exp);
    addr = 0;
  endtask

  task automatic cfg(int c, int ps, int sd, int dc, int fd, int pv);
    wr(c * 16 + 0, (sd << 6) | ps);
    wr(c * 16 + 4, (fd << 10) | dc);
    wr(c * 16 + 8, pv);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    idle(2);
    // R9 reset state
    check(pwm == 2'b00, "R9", "pwm in reset", int'(pwm), 0);
    rst_ni = 1;
    cmp_on = 1;
    rd(8'h00, 0, "R9"); rd(8'h14, 0, "R9");

    // R1 field masks, offsets, unmapped
    cur_req = "R1";
    wr(8'h00, 32'hFFFF_FFFF); rd(8'h00, 32'h7F, "R1");
    wr(8'h04, 32'hFFFF_FFFF); rd(8'h04, 32'h7FF, "R1");
    wr(8'h08, 32'hFFFF_FFFF); rd(8'h0A, 32'h3FF, "R1");
    rd(8'h0C, 0, "R1"); rd(8'h20, 0, "R1");
    wr(8'h28, 32'h155); rd(8'h08, 32'h3FF, "R1");
    wr(8'h18, 32'h2AA); rd(8'h18, 32'h2AA, "R1"); rd(8'h08, 32'h3FF, "R1");

    // R2 R3 explicit count: ps=1 pv=3 dc=2 -> period 8, high 4
    cur_req = "R2,R3";
    cfg(0, 1, 0, 2, 0, 3);
    @(negedge clk_i); en[0] = 1;
    begin
      int hi = 0, rises = 0; bit prev = 0;
      for (int k = 0; k < 16; k++) begin
        @(negedge clk_i); #1;
        hi += pwm[0];
        if (pwm[0] && !prev) rises++;
        prev = pwm[0];
      end
      check(hi == 8, "R3", "high clocks in 2 periods", hi, 8);
      check(rises == 2, "R2", "periods in 16 clocks", rises, 2);
    end
    idle(20);

    // R6 staged writes swept across every offset of the period
    cur_req = "R6";
    for (int k = 0; k < 10; k++) begin
      wr(8'h04, (k % 4) + 1); wr(8'h08, 2 + (k % 3));
      idle(k % 7);
    end
    idle(30);

    // R4 full duty overrides duty count
    cur_req = "R4";
    cfg(0, 2, 0, 0, 1, 4); idle(40);
    check(pwm[0] == 1'b1, "R4", "full duty high", int'(pwm[0]), 1);

    // R5 duty zero and duty above period
    cur_req = "R5";
    cfg(0, 0, 0, 0, 0, 5); idle(20);
    check(pwm[0] == 1'b0, "R5", "dc=0 low", int'(pwm[0]), 0);
    wr(8'h04, 6); idle(20);
    check(pwm[0] == 1'b1, "R5", "dc>pv high", int'(pwm[0]), 1);

    // R11 both channels together
    cur_req = "R11";
    cfg(0, 1, 0, 3, 0, 6);
    cfg(1, 3, 0, 1, 0, 2);
    @(negedge clk_i); en[1] = 1;
    idle(60);

    // R8 graceful stop at each offset, plus re-enable before the end
    cur_req = "R8";
    for (int k = 0; k < 9; k++) begin
      @(negedge clk_i); en[0] = 0;
      idle(k);
      if (k == 3) begin en[0] = 1; idle(5); en[0] = 0; end
      idle(20);
      check(pwm[0] == 1'b0, "R8", "idle after graceful stop", int'(pwm[0]), 0);
      en[0] = 1; idle(k + 2);
    end

    // R7 abrupt stop at each offset
    cur_req = "R7";
    wr(8'h00, (1 << 6) | 1);
    for (int k = 0; k < 9; k++) begin
      idle(k + 3);
      @(negedge clk_i); en[0] = 0;
      @(negedge clk_i); #1;
      check(pwm[0] == 1'b0, "R7", "low one clock after abrupt stop", int'(pwm[0]), 0);
      en[0] = 1;
    end
    en = 0; idle(30);

    // R10 single-channel build ignores channel 1
    cur_req = "R10";
    @(negedge clk_i); addr1 = 8'h14; wdata1 = 32'h3FF; we1 = 1;
    @(negedge clk_i); we1 = 0; addr1 = 8'h14;
    #1 check(rdata1 == 0, "R10", "absent ch duty", int'(rdata1), 0);
    @(negedge clk_i); addr1 = 8'h04; wdata1 = 32'h3FF; we1 = 1;
    @(negedge clk_i); we1 = 0; addr1 = 8'h04;
    #1 check(rdata1 == 32'h3FF, "R10", "present ch duty", int'(rdata1), 32'h3FF);
    addr1 = 8'h10;
    #1 check(rdata1 == 0, "R10", "absent ch ctrl", int'(rdata1), 0);

    idle(4);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule